// File: doc/BRIEF.md
# Staggered Four-Channel PWM Generator

The block produces four low-side drive signals for inductive loads from one shared 16-slot period counter that advances on a slow oscillator tick. Each channel runs at a duty set by a 4-bit code held in a register bank. The serial interface writes that bank when it has received a complete, valid frame. New codes are staged and take effect only when the counter wraps, so no partial pulse appears.

Channels 0 and 2 are aligned to the start of the period. Channels 1 and 3 are aligned to its end. This spreads the switching edges of neighbouring channels across the period.

Each channel has an overcurrent input that blanks its drive for the rest of the current period. A global undervoltage input holds every drive off without touching the stored codes. The internal PWM level of each channel is brought out together with one-cycle rise and fall strobes. The diagnostic capture logic samples its comparators on these strobes. The strobes keep running even when a channel's code is zero.

Top module: `stagger_pwm4`

## Requirements
- R1: `slot_o` resets to 0 and advances by one, modulo 16, in the cycle after each clock edge at which `tick_i` is high. Otherwise it holds. Channels 0 and 2 have `pwm_o` high while the slot is below the effective code e and low from slot e to slot 15. `drv_o[k]` is never high while `pwm_o[k]` is low.
- R2: Channels 1 and 3 have `pwm_o` high while the slot is at least 16−e and low in the slots before it.
- R3: Code 0 holds `drv_o[k]` low. For code 0 the internal level `pwm_o[k]` behaves as for code 15, so `rise_o` and `fall_o` still pulse.
- R4: `duty_i` bits [4k+3:4k] carry the code for channel k. The bank captures them only at a clock edge with `load_i` high. The captured codes become active at the next wrap, which is an edge with `tick_i` high while `slot_o` is 15.
- R5: While `ocp_i[k]` is high, `drv_o[k]` is low in the same cycle. If `ocp_i[k]` is high while `pwm_o[k]` is high, `drv_o[k]` stays low for the rest of the period. The blanking is cleared at the next wrap.
- R6: While `uv_i` is high, all of `drv_o` is low. The stored codes are kept, so drive resumes with the same duty once `uv_i` falls.
- R7: `rise_o[k]` is high for exactly the cycle in which `tick_i` is high and the edge will raise `pwm_o[k]`. `fall_o[k]` behaves the same way for a falling level. Both strobes are never high together, and neither is high without `tick_i`.
- R8: After reset, all codes are 0, `slot_o` is 0, `drv_o` is 0, and no strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle oscillator tick that advances the slot counter |
| load_i | input | 1 | Valid-frame strobe from the serial interface |
| duty_i | input | 16 | Four 4-bit duty codes; channel k in bits [4k+3:4k] |
| ocp_i | input | 4 | Per-channel overcurrent flags |
| uv_i | input | 1 | Undervoltage; forces all drives off |
| slot_o | output | 4 | Current period slot |
| pwm_o | output | 4 | Internal PWM level per channel |
| drv_o | output | 4 | Gated drive output per channel |
| rise_o | output | 4 | Rise strobe of the internal PWM level |
| fall_o | output | 4 | Fall strobe of the internal PWM level |

## Verification
`drv_o` reacts to `uv_i` and `ocp_i` in the same cycle. The strobes are high in the same cycle as the tick that causes the level change. `slot_o` and `pwm_o` change one cycle after the edge that samples the tick. A loaded code first affects `pwm_o` one cycle after the next wrap edge. The bench applies each input set at the falling clock edge and compares all outputs 1 ns later against a model state. It advances that model at the following rising edge, so every comparison falls in the cycle where the requirements place the result.

// File: rtl/spwm_pkg.sv
package spwm_pkg;
  localparam int CH_N   = 4;
  localparam int CODE_W = 4;
endpackage

// File: rtl/spwm_slot_ctr.sv
module spwm_slot_ctr #(
  parameter int CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  output logic [CW-1:0] slot_o,
  output logic [CW-1:0] slot_nxt_o,
  output logic          wrap_o
);
  logic [CW-1:0] slot_q;

  assign wrap_o     = tick_i && (slot_q == {CW{1'b1}});
  assign slot_nxt_o = tick_i ? slot_q + 1'b1 : slot_q;
  assign slot_o     = slot_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) slot_q <= '0;
    else         slot_q <= slot_nxt_o;
endmodule

// File: rtl/spwm_duty_bank.sv
module spwm_duty_bank #(
  parameter int CH_N = 4,
  parameter int CW   = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [CH_N*CW-1:0] duty_i,
  input  logic               wrap_i,
  output logic [CH_N*CW-1:0] act_o,
  output logic [CH_N*CW-1:0] act_nxt_o
);
  logic [CH_N*CW-1:0] pend_q, act_q;

  // staged codes move to the active set only at the period boundary
  assign act_nxt_o = wrap_i ? pend_q : act_q;
  assign act_o     = act_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      pend_q <= '0;
      act_q  <= '0;
    end else begin
      if (load_i) pend_q <= duty_i;
      act_q <= act_nxt_o;
    end
endmodule

// File: rtl/spwm_chan.sv
module spwm_chan #(
  parameter int CW        = 4,
  parameter bit END_ALIGN = 1'b0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          wrap_i,
  input  logic [CW-1:0] slot_i,
  input  logic [CW-1:0] slot_nxt_i,
  input  logic [CW-1:0] code_i,
  input  logic [CW-1:0] code_nxt_i,
  input  logic          ocp_i,
  input  logic          uv_i,
  output logic          pwm_o,
  output logic          rise_o,
  output logic          fall_o,
  output logic          drv_o
);
  localparam int SLOT_N = 1 << CW;

  function automatic logic level(input logic [CW-1:0] slot, input logic [CW-1:0] code);
    logic [CW-1:0] eff;
    eff = (code == '0) ? {CW{1'b1}} : code;  // zero code keeps the diag edges alive
    if (END_ALIGN) return int'(slot) >= SLOT_N - int'(eff);
    else           return int'(slot) <  int'(eff);
  endfunction

  logic lvl_now, lvl_nxt, blank_q;

  assign lvl_now = level(slot_i, code_i);
  assign lvl_nxt = level(slot_nxt_i, code_nxt_i);
  assign pwm_o   = lvl_now;
  assign rise_o  = tick_i && !lvl_now &&  lvl_nxt;
  assign fall_o  = tick_i &&  lvl_now && !lvl_nxt;
  assign drv_o   = lvl_now && (code_i != '0) && !uv_i && !ocp_i && !blank_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)     blank_q <= 1'b0;
    else if (wrap_i) blank_q <= 1'b0;
    else if (ocp_i && lvl_now) blank_q <= 1'b1;
endmodule

// File: rtl/stagger_pwm4.sv
module stagger_pwm4 #(
  parameter int CH_N   = spwm_pkg::CH_N,
  parameter int CODE_W = spwm_pkg::CODE_W
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   tick_i,
  input  logic                   load_i,
  input  logic [CH_N*CODE_W-1:0] duty_i,
  input  logic [CH_N-1:0]        ocp_i,
  input  logic                   uv_i,
  output logic [CODE_W-1:0]      slot_o,
  output logic [CH_N-1:0]        pwm_o,
  output logic [CH_N-1:0]        drv_o,
  output logic [CH_N-1:0]        rise_o,
  output logic [CH_N-1:0]        fall_o
);
  logic [CODE_W-1:0]      slot_nxt;
  logic                   wrap;
  logic [CH_N*CODE_W-1:0] act, act_nxt;

  spwm_slot_ctr #(.CW(CODE_W)) u_ctr (
    .clk_i, .rst_ni, .tick_i,
    .slot_o, .slot_nxt_o(slot_nxt), .wrap_o(wrap)
  );

  spwm_duty_bank #(.CH_N(CH_N), .CW(CODE_W)) u_bank (
    .clk_i, .rst_ni, .load_i, .duty_i,
    .wrap_i(wrap), .act_o(act), .act_nxt_o(act_nxt)
  );

  for (genvar k = 0; k < CH_N; k++) begin : g_ch
    // odd channels mirror the even ones to stagger edges
    spwm_chan #(.CW(CODE_W), .END_ALIGN((k % 2) == 1)) u_ch (
      .clk_i, .rst_ni, .tick_i,
      .wrap_i     (wrap),
      .slot_i     (slot_o),
      .slot_nxt_i (slot_nxt),
      .code_i     (act[k*CODE_W +: CODE_W]),
      .code_nxt_i (act_nxt[k*CODE_W +: CODE_W]),
      .ocp_i      (ocp_i[k]),
      .uv_i,
      .pwm_o      (pwm_o[k]),
      .rise_o     (rise_o[k]),
      .fall_o     (fall_o[k]),
      .drv_o      (drv_o[k])
    );
  end
endmodule

// File: rtl/stagger_pwm4_chk.sv
module stagger_pwm4_chk #(
  parameter int CH_N   = 4,
  parameter int CODE_W = 4
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   tick_i,
  input logic                   uv_i,
  input logic [CH_N-1:0]        ocp_i,
  input logic [CODE_W-1:0]      slot_o,
  input logic [CH_N-1:0]        pwm_o,
  input logic [CH_N-1:0]        drv_o,
  input logic [CH_N-1:0]        rise_o,
  input logic [CH_N-1:0]        fall_o,
  input logic [CH_N*CODE_W-1:0] act_i
);
  logic wrap_c;
  assign wrap_c = tick_i && (slot_o == {CODE_W{1'b1}});

  assert_slot_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(slot_o));
  assert_code_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrap_c |=> $stable(act_i));
  assert_uv_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uv_i |-> (drv_o == '0));
  assert_strobe_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_o & fall_o) == '0);
  assert_strobe_tick_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rise_o | fall_o) != '0) |-> tick_i);

  for (genvar k = 0; k < CH_N; k++) begin : g_a
    assert_drv_in_pwm_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      drv_o[k] |-> pwm_o[k]);
    assert_zero_off_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (act_i[k*CODE_W +: CODE_W] == '0) |-> !drv_o[k]);
    assert_ocp_now_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ocp_i[k] |-> !drv_o[k]);
    assert_ocp_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ocp_i[k] && pwm_o[k] && !wrap_c) |=> !drv_o[k]);
  end
endmodule

bind stagger_pwm4 stagger_pwm4_chk #(.CH_N(CH_N), .CODE_W(CODE_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .tick_i (tick_i),
  .uv_i   (uv_i),
  .ocp_i  (ocp_i),
  .slot_o (slot_o),
  .pwm_o  (pwm_o),
  .drv_o  (drv_o),
  .rise_o (rise_o),
  .fall_o (fall_o),
  .act_i  (act)
);

// File: tb/stagger_pwm4_tb.sv
`timescale 1ns/1ps
module stagger_pwm4_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0, load_i = 1'b0, uv_i = 1'b0;
  logic [15:0] duty_i = '0;
  logic [3:0]  ocp_i = '0;
  logic [3:0]  slot_o, pwm_o, drv_o, rise_o, fall_o;

  int checks = 0, errors = 0;
  int m_slot;
  int m_pend[4], m_act[4];
  bit m_blank[4];

  always #10 clk_i = ~clk_i;

  stagger_pwm4 u_dut (.*);

  function automatic bit lvl(int k, int s, int c);
    int e = (c == 0) ? 15 : c;
    if (k % 2 == 0) return s < e;
    return s >= 16 - e;
  endfunction

  task automatic chk(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(bit tk, bit ld, logic [15:0] du, logic [3:0] oc, bit uv);
    bit wrap;
    int nslot;
    int nact[4];
    logic [3:0] ep, ed, er, ef;
    @(negedge clk_i);
    tick_i = tk; load_i = ld; duty_i = du; ocp_i = oc; uv_i = uv;
    #1;
    wrap  = tk && (m_slot == 15);
    nslot = tk ? (m_slot + 1) % 16 : m_slot;
    for (int k = 0; k < 4; k++) begin
      nact[k] = wrap ? m_pend[k] : m_act[k];
      ep[k] = lvl(k, m_slot, m_act[k]);
      ed[k] = ep[k] && (m_act[k] != 0) && !uv && !oc[k] && !m_blank[k];
      er[k] = tk && !ep[k] && lvl(k, nslot, nact[k]);
      ef[k] = tk && ep[k] && !lvl(k, nslot, nact[k]);
    end
    chk("R1", slot_o, m_slot, "slot_o");
    for (int k = 0; k < 4; k++) begin
      chk((k % 2 == 0) ? "R1" : "R2", pwm_o[k], ep[k], $sformatf("pwm_o[%0d]", k));
      chk(uv ? "R6" : (oc[k] || m_blank[k]) ? "R5" : (m_act[k] == 0) ? "R3" : "R4",
          drv_o[k], ed[k], $sformatf("drv_o[%0d]", k));
    end
    chk("R7", rise_o, er, "rise_o");
    chk("R7", fall_o, ef, "fall_o");
    @(posedge clk_i);
    for (int k = 0; k < 4; k++) begin
      m_blank[k] = wrap ? 1'b0 : (m_blank[k] || (oc[k] && ep[k]));
      m_act[k] = nact[k];
      if (ld) m_pend[k] = int'(du[k*4 +: 4]);
    end
    m_slot = nslot;
  endtask

  task automatic run_period(logic [15:0] du, bit uv);
    for (int i = 0; i < 16; i++) step(1'b1, 1'b0, du, 4'h0, uv);
  endtask

  initial begin
    repeat (2000000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    m_slot = 0;
    for (int k = 0; k < 4; k++) begin m_pend[k] = 0; m_act[k] = 0; m_blank[k] = 0; end
    repeat (3) @(posedge clk_i);
    @(negedge clk_i); rst_ni = 1'b1; #1;
    // R8 reset state
    chk("R8", slot_o, 0, "slot_o after reset");
    chk("R8", drv_o, 0, "drv_o after reset");
    chk("R8", rise_o | fall_o, 0, "strobes after reset");

    // R4 load is staged until wrap; R1/R2 extremes 1 and 15
    step(1'b0, 1'b1, 16'hF1F1, 4'h0, 1'b0);
    run_period(16'h0, 1'b0);
    run_period(16'h0, 1'b0);
    // R3 zero codes mixed with 8
    step(1'b0, 1'b1, 16'h0808, 4'h0, 1'b0);
    run_period(16'h0, 1'b0);
    run_period(16'h0, 1'b0);
    // R6 undervoltage for a whole period, then release with codes kept
    step(1'b0, 1'b1, 16'h7C3A, 4'h0, 1'b0);
    run_period(16'h0, 1'b0);
    run_period(16'h0, 1'b1);
    run_period(16'h0, 1'b0);
    // R5 overcurrent one cycle inside the on-time of channel 0, then next periods
    for (int i = 0; i < 2; i++) step(1'b1, 1'b0, 16'h0, 4'h0, 1'b0);
    step(1'b0, 1'b0, 16'h0, 4'h1, 1'b0);
    for (int i = 0; i < 30; i++) step(1'b1, 1'b0, 16'h0, 4'h0, 1'b0);
    // R5 overcurrent on the wrap edge
    while (m_slot != 15) step(1'b1, 1'b0, 16'h0, 4'h0, 1'b0);
    step(1'b1, 1'b0, 16'h0, 4'hF, 1'b0);
    run_period(16'h0, 1'b0);

    // constrained random mix
    for (int i = 0; i < 6000; i++) begin
      bit tk = ($urandom_range(0, 1) == 1);
      bit ld = ($urandom_range(0, 39) == 0);
      logic [15:0] du = 16'($urandom);
      logic [3:0] oc = '0;
      bit uv = ($urandom_range(0, 63) == 0);
      if ($urandom_range(0, 2) == 0) du[4*$urandom_range(0, 3) +: 4] = 4'h0;
      for (int k = 0; k < 4; k++) oc[k] = ($urandom_range(0, 29) == 0);
      step(tk, ld, du, oc, uv);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule